// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status

This block is the receive half of an asynchronous serial port. It watches a single serial line and uses an external 16x oversampling tick to recover frames. Each frame has one start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. A good byte is placed in a holding buffer. The block also keeps three sticky flags and a busy indicator, and emits one receive-done pulse. That one pulse serves both as the interrupt request and as the DMA trigger.

There is no back-pressure on the data path. The holding buffer and the byte-ready flag behave as a simple register pair. Each new good byte overwrites the buffer whether or not software has read it. Software clears the flags by writing zeros to a three-bit status write port.

The receiver runs only while the mode input selects asynchronous operation and the enable input is high. The parity enable, parity sense and stop-bit count inputs are captured when the start edge is detected. They hold for the whole frame.

When two stop bits are configured, the byte and the done pulse are delivered as soon as the first stop bit samples high. A low second stop bit raises the framing flag one bit time later.

Top module: `async_rx_core`

## Requirements
- R1: After reset, all three flags, the data buffer, `rx_active` and `rx_done` are 0.
- R2: No frame is started while `mode_async` or `rx_enable` is 0. If either drops during a frame, the frame is abandoned: `rx_active` reads 0 on the following cycle and no flag is set by it.
- R3: A falling edge starts a frame only if the line is still low at the 8th oversampling tick. Otherwise the block returns to idle with no flag set.
- R4: Data bits are taken LSB first at the 16-tick mid-bit points. The buffer `rx_data` and `flag_byte` update on the same clock edge, at the first stop-bit sample, and only if that sample is high. The buffer does not change at any other time.
- R5: `rx_done` is a one-cycle pulse that is high on exactly the cycles in which `flag_byte` has just been set by a received byte.
- R6: With parity enabled, the parity bit follows the data bits. Even parity expects an even count of ones over the data and parity bits; odd parity expects an odd count. A mismatch sets `flag_parity` at the first stop-bit sample, and the byte is still delivered.
- R7: A low first stop bit sets `flag_frame`, leaves `flag_byte` and `rx_data` unchanged, and gives no `rx_done`.
- R8: With two stop bits, `rx_done` and `flag_byte` fire at the first stop-bit sample. A low second stop bit sets `flag_frame` 16 ticks later.
- R9: The flags are sticky. A cycle with `stat_wr` high clears each flag whose `stat_wdata` bit is 0, where bit 0 is byte, bit 1 is parity and bit 2 is framing. A 1 bit has no effect. A flag being set in the same cycle wins over the clear.
- R10: `rx_active` is 1 from the cycle after the start edge is detected until the last sample of the frame, or until a rejection or abort. It is 0 otherwise.
- R11: `par_en`, `par_odd` and `two_stop` are sampled at the start edge. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high, asynchronous |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_async | input | 1 | 1 selects asynchronous mode; 0 stops the receiver |
| rx_enable | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Write-zero-to-clear mask: [0] byte, [1] parity, [2] framing |
| rx_data | output | DATA_W (8) | Received byte buffer |
| flag_byte | output | 1 | Sticky byte-ready flag |
| flag_parity | output | 1 | Sticky parity error flag |
| flag_frame | output | 1 | Sticky framing error flag |
| rx_active | output | 1 | Frame in progress |
| rx_done | output | 1 | Receive-done pulse, used as both interrupt request and DMA trigger |

## Verification
The bench targets the following corner cases, each paired with the wrong behaviour it would expose:

- **Short start glitch.** A receiver that does not recheck the start bit at mid-bit would decode garbage.
- **Low second stop bit.** A design that waits for the full frame would delay `rx_done`. One that flags the error with the byte would raise the framing flag 16 ticks too early.
- **Even and odd parity, good and bad.** An inverted parity sense shows up here at once.
- **Bad first stop bit.** A design that still delivers the byte would move the buffer.
- **Clear writes.** Clears are tried with masked bits and in the same cycle as a set, to catch flags that are not sticky or that ignore the mask.
- **Mid-frame abort and configuration change.** These catch a receiver that keeps running when disabled, or one that reads the live parity and stop settings instead of the captured ones.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  localparam int FLAG_BYTE   = 0;
  localparam int FLAG_PARITY = 1;
  localparam int FLAG_FRAME  = 2;
  localparam int NUM_FLAGS   = 3;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import async_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              rx_s,
  input  frame_cfg_t        cfg_in,
  output logic              busy,
  output logic              evt_byte,
  output logic              evt_perr,
  output logic              evt_ferr,
  output logic [DATA_W-1:0] byte_out
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int HALF   = OSR / 2;
  localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t         state;
  frame_cfg_t        cfg;
  logic [CNT_W-1:0]  cnt;
  logic [BIDX_W-1:0] bidx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              prev;
  logic              fall;
  logic              mid_full;
  logic              mid_half;
  logic              par_bad;

  assign fall     = prev & ~rx_s;
  assign mid_full = tick && (cnt == CNT_W'(OSR - 1));
  assign mid_half = tick && (cnt == CNT_W'(HALF - 1));
  assign par_bad  = cfg.par_en && ((^shreg) ^ pbit ^ cfg.par_odd);
  assign busy     = (state != ST_IDLE);
  assign byte_out = shreg;

  always_comb begin
    evt_byte = 1'b0;
    evt_perr = 1'b0;
    evt_ferr = 1'b0;
    if (run && mid_full) begin
      if (state == ST_STOP1) begin
        evt_byte = rx_s;
        evt_ferr = ~rx_s;
        evt_perr = par_bad;
      end else if (state == ST_STOP2) begin
        evt_ferr = ~rx_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg   <= '0;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      prev  <= 1'b1;
    end else begin
      prev <= rx_s;
      if (!run) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (fall) begin
              state <= ST_START;
              cnt   <= '0;
              cfg   <= cfg_in;
            end
          end
          ST_START: begin
            if (mid_half) begin
              cnt  <= '0;
              bidx <= '0;
              state <= rx_s ? ST_IDLE : ST_DATA;
            end else if (tick) begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_DATA: begin
            if (mid_full) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              bidx  <= bidx + BIDX_W'(1);
              if (bidx == BIDX_W'(DATA_W - 1))
                state <= cfg.par_en ? ST_PARITY : ST_STOP1;
            end else if (tick) begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_PARITY: begin
            if (mid_full) begin
              cnt   <= '0;
              pbit  <= rx_s;
              state <= ST_STOP1;
            end else if (tick) begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_STOP1: begin
            if (mid_full) begin
              cnt   <= '0;
              state <= (rx_s && cfg.two_stop) ? ST_STOP2 : ST_IDLE;
            end else if (tick) begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_STOP2: begin
            if (mid_full) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else if (tick) begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [DATA_W-1:0]    byte_in,
  input  logic                 wr,
  input  logic [NUM_FLAGS-1:0] wmask,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]    data_buf,
  output logic                 done_pulse
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (wr && !wmask[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_buf   <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= set_vec[FLAG_BYTE];
      if (set_vec[FLAG_BYTE]) data_buf <= byte_in;
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              mode_async,
  input  logic              rx_enable,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              stat_wr,
  input  logic [2:0]        stat_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              flag_byte,
  output logic              flag_parity,
  output logic              flag_frame,
  output logic              rx_active,
  output logic              rx_done
);
  logic                 rx_s;
  logic                 run;
  frame_cfg_t           cfg_now;
  logic                 ev_byte, ev_perr, ev_ferr;
  logic [DATA_W-1:0]    shifted;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  assign run     = mode_async & rx_enable;
  assign cfg_now = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  rx_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  rx_deframer #(.OSR(OSR), .DATA_W(DATA_W)) u_defr (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(os_tick), .rx_s(rx_s),
    .cfg_in(cfg_now), .busy(rx_active), .evt_byte(ev_byte),
    .evt_perr(ev_perr), .evt_ferr(ev_ferr), .byte_out(shifted)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FLAG_BYTE]   = ev_byte;
    set_vec[FLAG_PARITY] = ev_perr;
    set_vec[FLAG_FRAME]  = ev_ferr;
  end

  rx_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .byte_in(shifted),
    .wr(stat_wr), .wmask(stat_wdata), .flags(flags),
    .data_buf(rx_data), .done_pulse(rx_done)
  );

  assign flag_byte   = flags[FLAG_BYTE];
  assign flag_parity = flags[FLAG_PARITY];
  assign flag_frame  = flags[FLAG_FRAME];
endmodule

// File: rtl/async_rx_core_chk.sv
module async_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_async,
  input logic              rx_enable,
  input logic              stat_wr,
  input logic [2:0]        stat_wdata,
  input logic [DATA_W-1:0] rx_data,
  input logic              flag_byte,
  input logic              flag_parity,
  input logic              flag_frame,
  input logic              rx_active,
  input logic              rx_done
);
  p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_async || !rx_enable) |=> !rx_active);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_done_with_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> flag_byte);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_data));

  p_sticky_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_byte && !(stat_wr && !stat_wdata[0])) |=> flag_byte);

  p_sticky_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_parity && !(stat_wr && !stat_wdata[1])) |=> flag_parity);

  p_sticky_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_frame && !(stat_wr && !stat_wdata[2])) |=> flag_frame);
endmodule

bind async_rx_core async_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .rx_enable(rx_enable),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .rx_data(rx_data),
  .flag_byte(flag_byte), .flag_parity(flag_parity), .flag_frame(flag_frame),
  .rx_active(rx_active), .rx_done(rx_done)
);

// File: tb/sim_async_rx_core.sv
module sim_async_rx_core;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       mode_async = 1'b0;
  logic       rx_enable = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       stat_wr = 1'b0;
  logic [2:0] stat_wdata = 3'b111;
  logic [7:0] rx_data;
  logic       flag_byte, flag_parity, flag_frame, rx_active, rx_done;

  int n_chk = 0;
  int n_bad = 0;
  int tcount = 0;
  int cycles = 0;

  async_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .mode_async(mode_async), .rx_enable(rx_enable), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .rx_data(rx_data), .flag_byte(flag_byte),
    .flag_parity(flag_parity), .flag_frame(flag_frame),
    .rx_active(rx_active), .rx_done(rx_done)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcount <= tcount + 1;
    os_tick <= ((tcount % 4) == 3);
  end

  // Reference model: tick counting since the start edge, behavioural.
  bit ms1 = 1, ms2 = 1, mprev = 1, mbusy = 0;
  int mt = 0;
  bit cpe = 0, codd = 0, ctwo = 0, mpb = 0;
  logic [7:0] msh = 0, mdata = 0;
  bit mbyte = 0, mferr = 0, mperr = 0, mdone = 0;

  always @(posedge clk) begin
    bit s2o, prevo, run;
    int j, st;
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; mprev = 1; mbusy = 0; mt = 0; msh = 0; mdata = 0;
      mbyte = 0; mferr = 0; mperr = 0; mdone = 0; mpb = 0;
    end else begin
      s2o = ms2; prevo = mprev; run = mode_async && rx_enable;
      mdone = 0;
      if (stat_wr) begin
        if (!stat_wdata[0]) mbyte = 0;
        if (!stat_wdata[1]) mperr = 0;
        if (!stat_wdata[2]) mferr = 0;
      end
      if (!run) mbusy = 0;
      else if (!mbusy) begin
        if (!s2o && prevo) begin
          mbusy = 1; mt = 0; cpe = par_en; codd = par_odd; ctwo = two_stop;
        end
      end else if (os_tick) begin
        mt++;
        if (mt >= 8 && ((mt - 8) % 16) == 0) begin
          j = (mt - 8) / 16;
          if (j == 0) begin
            if (s2o) mbusy = 0;
          end else if (j <= 8) msh[j-1] = s2o;
          else if (cpe && j == 9) mpb = s2o;
          else begin
            st = j - 9 - (cpe ? 1 : 0);
            if (st == 0) begin
              if (cpe && ((^msh) ^ mpb ^ codd)) mperr = 1;
              if (s2o) begin
                mdata = msh; mbyte = 1; mdone = 1;
                if (!ctwo) mbusy = 0;
              end else begin
                mferr = 1; mbusy = 0;
              end
            end else begin
              if (!s2o) mferr = 1;
              mbusy = 0;
            end
          end
        end
      end
      mprev = ms2; ms2 = ms1; ms1 = rx_line;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      if (n_bad < 40) $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, got, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 rx_data", rx_data, mdata);
      chk("R4 flag_byte", flag_byte, mbyte);
      chk("R5 rx_done", rx_done, mdone);
      chk("R6 flag_parity", flag_parity, mperr);
      chk("R7 flag_frame", flag_frame, mferr);
      chk("R10 rx_active", rx_active, mbusy);
    end
  end

  task automatic hold_bits(input int nbits);
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit pb,
                            input bit s1, input bit s2, input bit two);
    rx_line = 0; hold_bits(1);
    for (int i = 0; i < 8; i++) begin rx_line = d[i]; hold_bits(1); end
    if (pe) begin rx_line = pb; hold_bits(1); end
    rx_line = s1; hold_bits(1);
    if (two) begin rx_line = s2; hold_bits(1); end
    rx_line = 1; hold_bits(2);
  endtask

  task automatic clear_all();
    @(negedge clk); stat_wr = 1; stat_wdata = 3'b000;
    @(negedge clk); stat_wr = 0; stat_wdata = 3'b111;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset data", rx_data, 8'h00);
    chk("R1 reset flags", {flag_byte, flag_parity, flag_frame}, 3'b000);
    chk("R1 reset active/done", {rx_active, rx_done}, 2'b00);

    // R2: receiver off in sync mode, and when disabled
    rx_enable = 1; mode_async = 0;
    send_frame(8'h81, 0, 0, 1, 1, 0);
    chk("R2 mode off no byte", flag_byte, 0);
    mode_async = 1; rx_enable = 0;
    send_frame(8'h42, 0, 0, 1, 1, 0);
    chk("R2 disabled no byte", flag_byte, 0);
    rx_enable = 1; hold_bits(1);

    // R4: basic byte, LSB first
    send_frame(8'hA5, 0, 0, 1, 1, 0);
    chk("R4 data A5", rx_data, 8'hA5);
    chk("R4 byte flag", flag_byte, 1);

    // R9: write-one no effect, write-zero clears
    @(negedge clk); stat_wr = 1; stat_wdata = 3'b111;
    @(negedge clk); stat_wr = 0;
    @(negedge clk);
    chk("R9 write one keeps", flag_byte, 1);
    stat_wr = 1; stat_wdata = 3'b110;
    @(negedge clk); stat_wr = 0; stat_wdata = 3'b111;
    @(negedge clk);
    chk("R9 write zero clears", flag_byte, 0);

    // R6: even parity good then bad, odd parity good
    par_en = 1; par_odd = 0;
    send_frame(8'h3C, 1, ^8'h3C, 1, 1, 0);
    chk("R6 even good", {flag_byte, flag_parity}, 2'b10);
    send_frame(8'h07, 1, ~(^8'h07), 1, 1, 0);
    chk("R6 even bad", {flag_byte, flag_parity}, 2'b11);
    chk("R6 data kept", rx_data, 8'h07);
    clear_all();
    par_odd = 1;
    send_frame(8'h07, 1, ~(^8'h07), 1, 1, 0);
    chk("R6 odd good", flag_parity, 0);
    send_frame(8'h10, 1, ^8'h10, 1, 1, 0);
    chk("R6 odd bad", flag_parity, 1);
    par_en = 0; par_odd = 0;
    clear_all();

    // R7: low first stop bit
    send_frame(8'hEE, 0, 0, 0, 1, 0);
    chk("R7 framing set", flag_frame, 1);
    chk("R7 no byte", flag_byte, 0);
    chk("R7 data unchanged", rx_data, 8'h10);
    clear_all();

    // R8: two stop bits, second low: frame flag one bit later
    two_stop = 1;
    fork
      send_frame(8'h5E, 0, 0, 1, 0, 1);
      begin
        while (!rx_done) @(negedge clk);
        chk("R8 byte at first stop", {flag_byte, flag_frame}, 2'b10);
        repeat (BITCLK - 4) @(negedge clk);
        chk("R8 frame not yet", flag_frame, 0);
        repeat (8) @(negedge clk);
        chk("R8 frame one bit later", flag_frame, 1);
      end
    join
    two_stop = 0;

    // R9: set wins over simultaneous clear (driven on every cycle of the frame)
    fork
      send_frame(8'h99, 0, 0, 1, 1, 0);
      begin
        while (!rx_done) begin stat_wr = 1; stat_wdata = 3'b000; @(negedge clk); end
        stat_wr = 0; stat_wdata = 3'b111;
      end
    join
    chk("R9 set wins", flag_byte, 1);
    clear_all();

    // R3: start glitch shorter than half a bit
    rx_line = 0; repeat (16) @(negedge clk);
    rx_line = 1; hold_bits(2);
    chk("R3 glitch rejected", {flag_byte, flag_frame, rx_active}, 3'b000);

    // R11: config change mid-frame ignored
    fork
      send_frame(8'h5A, 0, 0, 1, 1, 0);
      begin
        repeat (200) @(negedge clk);
        par_en = 1; two_stop = 1;
      end
    join
    chk("R11 data", rx_data, 8'h5A);
    chk("R11 no parity/frame", {flag_parity, flag_frame}, 2'b00);
    par_en = 0; two_stop = 0;
    clear_all();

    // R2: abort mid-frame
    rx_line = 0; hold_bits(3);
    chk("R10 busy mid-frame", rx_active, 1);
    rx_enable = 0;
    @(negedge clk);
    chk("R2 abort drops active", rx_active, 0);
    rx_line = 1; hold_bits(2);
    rx_enable = 1; hold_bits(10);
    chk("R2 abort no flags", {flag_byte, flag_parity, flag_frame}, 3'b000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule